// File: doc/BRIEF.md
# Doorbell Window Decoder

The block sits behind a 32-bit register window that software uses to ring doorbells. Every user context is given one 4 KB page of the window. The block uses only the offset inside the page, so every page decodes in the same way. The offset selects a target: queue pair, completion queue or shared receive queue. Command bits in the written word select which actions fire, and the low bits of the word carry the handle of the object the action applies to.

The strobes are registered and appear together, each for one clock, in the cycle after the write. One write can raise several strobes at once: send and receive on a queue pair, or arm and poll on a completion queue. A write to an offset that decodes to no target raises an error strobe and no command strobe. A wrapping counter counts every write. Any read of the window returns all ones, one cycle after the read request.

Top module: `doorbell_decoder`

## Requirements
- R1: A read request (`rd_en`) gives `rd_valid` high in the next cycle, with `rd_data` = 0xFFFFFFFF. The read address does not matter.
- R2: Only `wr_addr[11:0]` selects the target. Writes that differ only in bits 12 and above give the same strobes.
- R3: At offset 0x000, bit 30 raises `qp_send` and bit 31 raises `qp_recv`. Both can fire from one write. `cmd_handle` carries `wr_data[23:0]`.
- R4: At offset 0x008, bit 30 raises `cq_arm` with the handle. `cq_arm_sol` copies bit 29, but only while `cq_arm` fires. Bit 29 without bit 30 fires nothing.
- R5: At offset 0x008, bit 31 raises `cq_poll` with the handle, whatever the state of the arm bit.
- R6: At offset 0x018, bit 31 raises `srq_recv` with the handle. Other bits at this offset fire nothing.
- R7: A write to any other 12-bit offset raises `bad_offset` and no command strobe, whatever data is written.
- R8: `wr_count` resets to 0 and goes up by one on every write, including writes to a bad offset and writes with no command bits. It wraps from 2^CNT_W-1 to 0.
- R9: All strobes appear in the cycle after the write and last exactly one cycle. Back-to-back writes give strobes in back-to-back cycles.
- R10: A write to a valid offset that carries none of that offset's command bits fires no strobe and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request, one word per cycle |
| wr_addr | input | ADDR_W | Byte address of the write within the window |
| wr_data | input | 32 | Written value |
| rd_en | input | 1 | Read request |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 32 | Read data: all ones on a read, zero otherwise |
| qp_send | output | 1 | Queue-pair send strobe |
| qp_recv | output | 1 | Queue-pair receive strobe |
| cq_arm | output | 1 | Completion-queue arm strobe |
| cq_arm_sol | output | 1 | Solicited-only flag that goes with `cq_arm` |
| cq_poll | output | 1 | Completion-queue poll strobe |
| srq_recv | output | 1 | Shared-receive-queue receive strobe |
| bad_offset | output | 1 | Unsupported-offset error strobe |
| cmd_handle | output | HANDLE_W | Handle of the most recent write |
| wr_count | output | CNT_W | Count of writes, wrapping |

## Verification
The hardest case is the one where several actions share one write and sit among writes that fire nothing. A bug there can drop one strobe, or leave a strobe from an earlier write standing. The bench therefore writes back-to-back words that combine command bits at each offset. It mixes these with writes that only set the solicited bit, writes with no command bits, and writes to bad offsets that have every bit set. In every cycle in which no result is due, the monitor checks that all strobes are low. Page aliasing is covered by repeating the same words in pages above page zero. Counter wrap is reached by building the bench with a narrow counter.

// File: rtl/db_pkg.sv
package db_pkg;
  localparam int OFF_W        = 12;
  localparam int DATA_W       = 32;
  localparam logic [OFF_W-1:0] OFF_QP  = 12'h000;
  localparam logic [OFF_W-1:0] OFF_CQ  = 12'h008;
  localparam logic [OFF_W-1:0] OFF_SRQ = 12'h018;

  localparam int BIT_QP_SEND  = 30;
  localparam int BIT_QP_RECV  = 31;
  localparam int BIT_CQ_ARM   = 30;
  localparam int BIT_CQ_SOL   = 29;
  localparam int BIT_CQ_POLL  = 31;
  localparam int BIT_SRQ_RECV = 31;

  typedef enum logic [1:0] {
    TGT_QP   = 2'd0,
    TGT_CQ   = 2'd1,
    TGT_SRQ  = 2'd2,
    TGT_NONE = 2'd3
  } db_target_e;

  typedef struct packed {
    logic qp_send;
    logic qp_recv;
    logic cq_arm;
    logic cq_sol;
    logic cq_poll;
    logic srq_recv;
    logic bad_off;
  } db_strobe_t;
endpackage

// File: rtl/db_offset_decode.sv
module db_offset_decode
  import db_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output db_target_e        target
);
  logic [OFF_W-1:0] page_off;

  generate
    if (ADDR_W > OFF_W) begin : g_wide
      logic unused_page_bits;
      assign unused_page_bits = ^addr[ADDR_W-1:OFF_W];
      assign page_off = addr[OFF_W-1:0];
    end else begin : g_narrow
      assign page_off = OFF_W'(addr);
    end
  endgenerate

  always_comb begin
    unique case (page_off)
      OFF_QP:  target = TGT_QP;
      OFF_CQ:  target = TGT_CQ;
      OFF_SRQ: target = TGT_SRQ;
      default: target = TGT_NONE;
    endcase
  end
endmodule

// File: rtl/db_cmd_gen.sv
module db_cmd_gen
  import db_pkg::*;
#(
  parameter int HANDLE_W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  db_target_e          target,
  input  logic [DATA_W-1:0]   data,
  output db_strobe_t          stb_q,
  output logic [HANDLE_W-1:0] handle_q
);
  db_strobe_t stb_d;
  logic unused_mid_bits;
  assign unused_mid_bits = ^data[BIT_CQ_SOL-1:HANDLE_W];

  always_comb begin
    stb_d = '0;
    if (wr_en) begin
      unique case (target)
        TGT_QP: begin
          stb_d.qp_send = data[BIT_QP_SEND];
          stb_d.qp_recv = data[BIT_QP_RECV];
        end
        TGT_CQ: begin
          stb_d.cq_arm  = data[BIT_CQ_ARM];
          stb_d.cq_sol  = data[BIT_CQ_ARM] & data[BIT_CQ_SOL];
          stb_d.cq_poll = data[BIT_CQ_POLL];
        end
        TGT_SRQ: stb_d.srq_recv = data[BIT_SRQ_RECV];
        default: stb_d.bad_off  = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_q    <= '0;
      handle_q <= '0;
    end else begin
      stb_q <= stb_d;
      if (wr_en) handle_q <= data[HANDLE_W-1:0];
    end
  end
endmodule

// File: rtl/db_wr_counter.sv
module db_wr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (inc) count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/db_read_resp.sv
module db_read_resp
  import db_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= rd_en ? '1 : '0;
    end
  end
endmodule

// File: rtl/doorbell_decoder.sv
module doorbell_decoder
  import db_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int HANDLE_W = 24,
  parameter int CNT_W    = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [31:0]         wr_data,
  input  logic                rd_en,
  output logic                rd_valid,
  output logic [31:0]         rd_data,
  output logic                qp_send,
  output logic                qp_recv,
  output logic                cq_arm,
  output logic                cq_arm_sol,
  output logic                cq_poll,
  output logic                srq_recv,
  output logic                bad_offset,
  output logic [HANDLE_W-1:0] cmd_handle,
  output logic [CNT_W-1:0]    wr_count
);
  db_target_e target;
  db_strobe_t stb;

  db_offset_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr   (wr_addr),
    .target (target)
  );

  db_cmd_gen #(.HANDLE_W(HANDLE_W)) u_cmd (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .target   (target),
    .data     (wr_data),
    .stb_q    (stb),
    .handle_q (cmd_handle)
  );

  db_wr_counter #(.CNT_W(CNT_W)) u_count (
    .clk   (clk),
    .rst   (rst),
    .inc   (wr_en),
    .count (wr_count)
  );

  db_read_resp u_read (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  assign qp_send    = stb.qp_send;
  assign qp_recv    = stb.qp_recv;
  assign cq_arm     = stb.cq_arm;
  assign cq_arm_sol = stb.cq_sol;
  assign cq_poll    = stb.cq_poll;
  assign srq_recv   = stb.srq_recv;
  assign bad_offset = stb.bad_off;
endmodule

// File: rtl/db_checker.sv
module db_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             rd_en,
  input logic             rd_valid,
  input logic [31:0]      rd_data,
  input logic             qp_send,
  input logic             qp_recv,
  input logic             cq_arm,
  input logic             cq_arm_sol,
  input logic             cq_poll,
  input logic             srq_recv,
  input logic             bad_offset,
  input logic [CNT_W-1:0] wr_count
);
  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  logic any_cmd;
  assign any_cmd = qp_send | qp_recv | cq_arm | cq_poll | srq_recv;

  assert_read_ones_R1: assert property (@(posedge clk) disable iff (rst || !armed)
    rd_valid |-> (rd_data == 32'hFFFF_FFFF));
  assert_read_latency_R1: assert property (@(posedge clk) disable iff (rst || !armed)
    rd_valid |-> $past(rd_en));
  assert_sol_needs_arm_R4: assert property (@(posedge clk) disable iff (rst || !armed)
    cq_arm_sol |-> cq_arm);
  assert_bad_exclusive_R7: assert property (@(posedge clk) disable iff (rst || !armed)
    bad_offset |-> !any_cmd);
  assert_count_step_R8: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(wr_en) |-> (wr_count == $past(wr_count) + CNT_W'(1)));
  assert_count_hold_R8: assert property (@(posedge clk) disable iff (rst || !armed)
    !$past(wr_en) |-> $stable(wr_count));
  assert_strobe_after_write_R9: assert property (@(posedge clk) disable iff (rst || !armed)
    (any_cmd || bad_offset) |-> $past(wr_en));
endmodule

bind doorbell_decoder db_checker #(.CNT_W(CNT_W)) u_db_checker (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .rd_valid   (rd_valid),
  .rd_data    (rd_data),
  .qp_send    (qp_send),
  .qp_recv    (qp_recv),
  .cq_arm     (cq_arm),
  .cq_arm_sol (cq_arm_sol),
  .cq_poll    (cq_poll),
  .srq_recv   (srq_recv),
  .bad_offset (bad_offset),
  .wr_count   (wr_count)
);

// File: tb/test_doorbell_decoder.sv
module test_doorbell_decoder;
  localparam int AW = 16;
  localparam int HW = 24;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic          rd_en = 1'b0;
  logic          rd_valid;
  logic [31:0]   rd_data;
  logic          qp_send, qp_recv, cq_arm, cq_arm_sol, cq_poll, srq_recv, bad_offset;
  logic [HW-1:0] cmd_handle;
  logic [CW-1:0] wr_count;

  always #4 clk = ~clk;

  doorbell_decoder #(.ADDR_W(AW), .HANDLE_W(HW), .CNT_W(CW)) i_doorbell_decoder (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data),
    .qp_send(qp_send), .qp_recv(qp_recv), .cq_arm(cq_arm), .cq_arm_sol(cq_arm_sol),
    .cq_poll(cq_poll), .srq_recv(srq_recv), .bad_offset(bad_offset),
    .cmd_handle(cmd_handle), .wr_count(wr_count)
  );

  typedef struct {
    int          due;
    bit          is_rd;
    logic [6:0]  stb;
    logic [HW-1:0] hnd;
    logic [CW-1:0] cnt;
    string       req;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int checks = 0;
  int fails = 0;
  logic [CW-1:0] cnt_model = '0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [6:0] model(input logic [AW-1:0] a, input logic [31:0] d);
    logic [6:0] s;
    s = '0;
    case (a[11:0])
      12'h000: begin s[6] = d[30]; s[5] = d[31]; end
      12'h008: begin s[4] = d[30]; s[3] = d[30] & d[29]; s[2] = d[31]; end
      12'h018: s[1] = d[31];
      default: s[0] = 1'b1;
    endcase
    return s;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d, input string req);
    item_t it;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cnt_model = cnt_model + CW'(1);
    it.due = cyc + 1; it.is_rd = 1'b0; it.stb = model(a, d);
    it.hnd = d[HW-1:0]; it.cnt = cnt_model; it.req = req;
    q.push_back(it);
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic do_read(input string req);
    item_t it;
    @(negedge clk);
    rd_en = 1'b1;
    it.due = cyc + 1; it.is_rd = 1'b1; it.stb = '0;
    it.hnd = '0; it.cnt = cnt_model; it.req = req;
    q.push_back(it);
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  // Monitor: pops due items and checks idle cycles (R9 single-cycle strobes)
  always @(negedge clk) begin
    logic [6:0] s;
    s = {qp_send, qp_recv, cq_arm, cq_arm_sol, cq_poll, srq_recv, bad_offset};
    if (!rst && !done) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        item_t it;
        it = q.pop_front();
        check(it.req, "strobes", 32'(s), 32'(it.stb));
        check(it.req, "rd_valid", 32'(rd_valid), 32'(it.is_rd));
        if (it.is_rd) check(it.req, "rd_data", rd_data, 32'hFFFF_FFFF);
        else          check(it.req, "wr_count", 32'(wr_count), 32'(it.cnt));
        if (|it.stb[6:1]) check(it.req, "handle", 32'(cmd_handle), 32'(it.hnd));
      end else begin
        check("R9", "idle strobes", {24'd0, s, rd_valid}, 32'd0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R8", "reset count", 32'(wr_count), 32'd0);
    check("R9", "reset strobes", {25'd0, qp_send, qp_recv, cq_arm, cq_arm_sol, cq_poll, srq_recv, bad_offset}, 32'd0);
    check("R1", "reset rd_valid", 32'(rd_valid), 32'd0);

    // R3 queue pair
    do_write(16'h0000, 32'h4000_0123, "R3");
    do_write(16'h0000, 32'h8000_0456, "R3");
    do_write(16'h0000, 32'hC0AB_CDEF, "R3");
    // R10 no command bits
    do_write(16'h0000, 32'h0000_0077, "R10");
    do_write(16'h0008, 32'h0000_0001, "R10");
    // R4 arm / solicited
    do_write(16'h0008, 32'h4000_0011, "R4");
    do_write(16'h0008, 32'h6000_0022, "R4");
    do_write(16'h0008, 32'h2000_0033, "R4");
    // R5 poll independent of arm
    do_write(16'h0008, 32'h8000_0044, "R5");
    do_write(16'h0008, 32'hE000_0055, "R5");
    // R6 shared receive
    do_write(16'h0018, 32'h8000_0066, "R6");
    do_write(16'h0018, 32'h7FFF_FFFF, "R6");
    // R7 bad offsets
    do_write(16'h0004, 32'hFFFF_FFFF, "R7");
    do_write(16'h0010, 32'hC000_0001, "R7");
    do_write(16'h0FFC, 32'h8000_0002, "R7");
    // R2 page aliasing
    do_write(16'h3000, 32'hC000_0abc, "R2");
    do_write(16'hF008, 32'hE000_0def, "R2");
    do_write(16'hA018, 32'h8000_0fed, "R2");
    do_write(16'h5004, 32'h4000_0000, "R2");
    // R1 reads
    do_read("R1");
    do_read("R1");
    // R8 wrap of the narrow counter
    for (int i = 0; i < 20; i++) do_write(16'(i * 4), 32'hC000_0000 | 32'(i), "R8");

    repeat (4) @(negedge clk);
    check("R9", "queue drained", 32'(q.size()), 32'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule